// File: doc/BRIEF.md
# Paged Memory Window Address Translator

This block sits between an 8-bit processor with a 16-bit address bus and a 128 KB physical memory built from eight 16 KB pages. The 64 KB logical map is cut into four 16 KB slots by the two top address bits. The lowest slot reaches RAM and peripheral registers. Two slots are wired to fixed flash pages. The remaining slot is a window whose physical page comes from a small page-select register.

The processor writes the page-select register over a plain write-enable/data port and can read it back at any time. Address translation is purely combinational. Every processor address yields a 17-bit physical address and a one-hot pair of region selects (RAM/registers or flash) in the same cycle. A register write changes the window mapping from the clock edge that captures it onward.

Top module: `page_window_xlat`

## Requirements
- R1: After reset the page-select register reads 0x02, and logical 0x8000 translates to physical 0x08000.
- R2: A logical address in 0x8000–0xBFFF translates to physical {page[2:0], addr[13:0]}, with the flash select asserted.
- R3: A logical address in 0xC000–0xFFFF translates to physical 0x0C000 + addr[13:0] (page 3) with the flash select asserted, whatever the register holds.
- R4: A logical address in 0x4000–0x7FFF translates to physical 0x04000 + addr[13:0] (page 1) with the flash select asserted, whatever the register holds.
- R5: A logical address in 0x0000–0x3FFF asserts the RAM select and translates to physical {3'b000, addr[13:0]}, whatever the register holds.
- R6: Write data bits 7:3 are discarded. The read-back value carries the stored page in bits 2:0 and zero in bits 7:3.
- R7: A write presented with cfg_we high changes neither the read-back value nor the window translation before the next rising clock edge. Both show the new page after that edge. A change of cpu_addr alone updates the outputs with no clock edge.
- R8: Exactly one of sel_ram and sel_flash is high for every address.
- R9: While cfg_we is low, the register keeps its value, whatever cfg_wdata carries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the page-select register |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Page-select register write enable |
| cfg_wdata | input | 8 | Page-select write data |
| cfg_rdata | output | 8 | Page-select read-back value |
| cpu_addr | input | 16 | Logical processor address |
| phys_addr | output | 17 | Translated physical address |
| sel_ram | output | 1 | Access targets RAM/register region |
| sel_flash | output | 1 | Access targets flash |

## Verification
A page-register write and the translation of a window address can occur in the same cycle. The bench holds a window address on cpu_addr while it raises cfg_we with a new page. It samples the physical address just after the falling edge, where it must still show the old page. It samples again just after the next rising edge, where it must show the new page. The same pattern, with cfg_we low and cfg_wdata toggling, confirms that nothing moves without a write.

// File: rtl/pgwin_pkg.sv
package pgwin_pkg;

   typedef enum logic [1:0] {
      REGION_RAM    = 2'd0,
      REGION_FIXED  = 2'd1,
      REGION_WINDOW = 2'd2
   } region_e;

endpackage

// File: rtl/pgwin_page_reg.sv
module pgwin_page_reg #(
   parameter int unsigned REG_W      = 8,
   parameter int unsigned PSEL_W     = 3,
   parameter int unsigned RESET_PAGE = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [REG_W-1:0]  wdata,
   output logic [PSEL_W-1:0] page_q,
   output logic [REG_W-1:0]  rdata
);

   localparam logic [PSEL_W-1:0] RST_VAL = PSEL_W'(RESET_PAGE);

   logic unused_wbits;
   assign unused_wbits = ^wdata[REG_W-1:PSEL_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  page_q <= RST_VAL;
      else if (we) page_q <= wdata[PSEL_W-1:0];
   end

   always_comb begin
      rdata = '0;
      rdata[PSEL_W-1:0] = page_q;
   end

   // R7: a write is visible on the read port one cycle later
   a_r7_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> (rdata[PSEL_W-1:0] == $past(wdata[PSEL_W-1:0])));

   // R9: no write, no change
   a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !we |=> $stable(page_q));

   // R6: upper read bits are always zero
   a_r6_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
      rdata[REG_W-1:PSEL_W] == '0);

endmodule

// File: rtl/pgwin_slot_decode.sv
module pgwin_slot_decode
   import pgwin_pkg::*;
#(
   parameter int unsigned SLOT_W      = 2,
   parameter int unsigned PSEL_W      = 3,
   parameter int unsigned RAM_SLOT    = 0,
   parameter int unsigned WINDOW_SLOT = 2,
   parameter logic [(2**SLOT_W)*PSEL_W-1:0] FIXED_MAP = {3'd3, 3'd2, 3'd1, 3'd0}
) (
   input  logic [SLOT_W-1:0] slot,
   input  logic [PSEL_W-1:0] page_q,
   output region_e           region,
   output logic [PSEL_W-1:0] phys_page
);

   localparam int unsigned NUM_SLOTS = 2**SLOT_W;

   logic [PSEL_W-1:0] slot_page [NUM_SLOTS];
   region_e           slot_kind [NUM_SLOTS];

   for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
      if (i == RAM_SLOT) begin : g_ram
         assign slot_page[i] = '0;
         assign slot_kind[i] = REGION_RAM;
      end else if (i == WINDOW_SLOT) begin : g_win
         assign slot_page[i] = page_q;
         assign slot_kind[i] = REGION_WINDOW;
      end else begin : g_fix
         assign slot_page[i] = FIXED_MAP[i*PSEL_W +: PSEL_W];
         assign slot_kind[i] = REGION_FIXED;
      end
   end

   assign phys_page = slot_page[slot];
   assign region    = slot_kind[slot];

endmodule

// File: rtl/pgwin_addr_compose.sv
module pgwin_addr_compose
   import pgwin_pkg::*;
#(
   parameter int unsigned PAGE_AW = 14,
   parameter int unsigned PSEL_W  = 3,
   localparam int unsigned PHYS_AW = PAGE_AW + PSEL_W
) (
   input  region_e            region,
   input  logic [PSEL_W-1:0]  phys_page,
   input  logic [PAGE_AW-1:0] offset,
   output logic [PHYS_AW-1:0] phys_addr,
   output logic               sel_ram,
   output logic               sel_flash
);

   always_comb begin
      sel_ram   = (region == REGION_RAM);
      sel_flash = !sel_ram;
      phys_addr = {phys_page, offset};
   end

   // R5: RAM accesses never carry a page number
   always_comb begin
      if (sel_ram)
         a_r5_ram_unpaged: assert (phys_addr[PHYS_AW-1:PAGE_AW] == '0 || $isunknown(phys_page));
   end

endmodule

// File: rtl/page_window_xlat.sv
module page_window_xlat #(
   parameter int unsigned LOG_AW      = 16,
   parameter int unsigned PAGE_AW     = 14,
   parameter int unsigned PSEL_W      = 3,
   parameter int unsigned REG_W       = 8,
   parameter int unsigned RESET_PAGE  = 2,
   parameter int unsigned RAM_SLOT    = 0,
   parameter int unsigned WINDOW_SLOT = 2,
   parameter logic [(2**(LOG_AW-PAGE_AW))*PSEL_W-1:0] FIXED_MAP = {3'd3, 3'd2, 3'd1, 3'd0}
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      cfg_we,
   input  logic [REG_W-1:0]          cfg_wdata,
   output logic [REG_W-1:0]          cfg_rdata,
   input  logic [LOG_AW-1:0]         cpu_addr,
   output logic [PAGE_AW+PSEL_W-1:0] phys_addr,
   output logic                      sel_ram,
   output logic                      sel_flash
);
   import pgwin_pkg::*;

   localparam int unsigned SLOT_W    = LOG_AW - PAGE_AW;
   localparam int unsigned NUM_SLOTS = 2**SLOT_W;
   localparam int unsigned PHYS_AW   = PAGE_AW + PSEL_W;
   localparam logic [SLOT_W-1:0] WIN_IDX = SLOT_W'(WINDOW_SLOT);

   if (PSEL_W > REG_W) begin : g_chk_w
      $error("page field wider than register");
   end
   if (RESET_PAGE >= 2**PSEL_W) begin : g_chk_rst
      $error("reset page out of range");
   end
   if (WINDOW_SLOT == RAM_SLOT || WINDOW_SLOT >= NUM_SLOTS || RAM_SLOT >= NUM_SLOTS) begin : g_chk_slot
      $error("bad slot assignment");
   end

   logic [PSEL_W-1:0] page_q;
   logic [PSEL_W-1:0] phys_page;
   region_e           region;

   pgwin_page_reg #(
      .REG_W(REG_W), .PSEL_W(PSEL_W), .RESET_PAGE(RESET_PAGE)
   ) u_reg (
      .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_wdata),
      .page_q(page_q), .rdata(cfg_rdata)
   );

   pgwin_slot_decode #(
      .SLOT_W(SLOT_W), .PSEL_W(PSEL_W), .RAM_SLOT(RAM_SLOT),
      .WINDOW_SLOT(WINDOW_SLOT), .FIXED_MAP(FIXED_MAP)
   ) u_dec (
      .slot(cpu_addr[LOG_AW-1:PAGE_AW]), .page_q(page_q),
      .region(region), .phys_page(phys_page)
   );

   pgwin_addr_compose #(
      .PAGE_AW(PAGE_AW), .PSEL_W(PSEL_W)
   ) u_cmp (
      .region(region), .phys_page(phys_page), .offset(cpu_addr[PAGE_AW-1:0]),
      .phys_addr(phys_addr), .sel_ram(sel_ram), .sel_flash(sel_flash)
   );

   // R8: one region at a time
   a_r8_one_region: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot({sel_ram, sel_flash}));

   // R2: window page follows the register
   a_r2_window_follows: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_addr[LOG_AW-1:PAGE_AW] == WIN_IDX) |->
         (phys_addr[PHYS_AW-1:PAGE_AW] == cfg_rdata[PSEL_W-1:0] && sel_flash));

   // R2: the in-page offset is always passed through
   a_r2_offset_through: assert property (@(posedge clk) disable iff (!rst_n)
      phys_addr[PAGE_AW-1:0] == cpu_addr[PAGE_AW-1:0]);

   // R3 R4: fixed slots do not move when the register is written
   a_r4_fixed_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_addr[LOG_AW-1:PAGE_AW] != WIN_IDX && $stable(cpu_addr)) |-> $stable(phys_addr));

endmodule

// File: tb/page_window_xlat_tb_top.sv
module page_window_xlat_tb_top;

   localparam int CLK_P = 10;
   localparam int NV    = 12;
   // {write value, logical address, expected physical, expected sel_ram}
   localparam logic [41:0] VEC [NV] = '{
      {8'h05, 16'h8000, 17'h14000, 1'b0},
      {8'h05, 16'hBFFF, 17'h17FFF, 1'b0},
      {8'hFF, 16'h8123, 17'h1C123, 1'b0},
      {8'hF8, 16'h9ABC, 17'h01ABC, 1'b0},
      {8'h06, 16'hC000, 17'h0C000, 1'b0},
      {8'h06, 16'hFFFF, 17'h0FFFF, 1'b0},
      {8'h00, 16'h4000, 17'h04000, 1'b0},
      {8'h07, 16'h7FFF, 17'h07FFF, 1'b0},
      {8'h07, 16'h0000, 17'h00000, 1'b1},
      {8'h04, 16'h3FFF, 17'h03FFF, 1'b1},
      {8'h03, 16'hA55A, 17'h0E55A, 1'b0},
      {8'h01, 16'h1234, 17'h01234, 1'b1}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [7:0]  cfg_wdata = '0;
   logic [7:0]  cfg_rdata;
   logic [15:0] cpu_addr = '0;
   logic [16:0] phys_addr;
   logic        sel_ram, sel_flash;

   int n_chk = 0;
   int n_bad = 0;

   always #(CLK_P/2) clk = ~clk;

   page_window_xlat dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
      .cfg_rdata(cfg_rdata), .cpu_addr(cpu_addr), .phys_addr(phys_addr),
      .sel_ram(sel_ram), .sel_flash(sel_flash)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic write_page(input logic [7:0] v);
      @(negedge clk);
      cfg_we = 1'b1;
      cfg_wdata = v;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   function automatic string tag_of(input logic [15:0] a);
      case (a[15:14])
         2'd0: return "R5";
         2'd1: return "R4";
         2'd2: return "R2";
         default: return "R3";
      endcase
   endfunction

   initial begin
      #(CLK_P * 200000);
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      cpu_addr = 16'h8000;
      #1;
      // R1 reset state
      chk("R1 rdata", 32'(cfg_rdata), 32'h02);
      chk("R1 window", 32'(phys_addr), 32'h08000);

      foreach (VEC[i]) begin
         write_page(VEC[i][41:34]);
         cpu_addr = VEC[i][33:18];
         #1;
         chk(tag_of(VEC[i][33:18]), 32'(phys_addr), 32'(VEC[i][17:1]));
         chk("R8 ram", 32'(sel_ram), 32'(VEC[i][0]));
         chk("R8 flash", 32'(sel_flash), 32'(!VEC[i][0]));
         chk("R6 rdata", 32'(cfg_rdata), 32'(VEC[i][36:34]));
      end

      // R7: write and window translation in the same cycle
      write_page(8'h01);
      cpu_addr = 16'h8010;
      @(negedge clk);
      cfg_we = 1'b1;
      cfg_wdata = 8'h06;
      #1;
      chk("R7 before edge", 32'(phys_addr), 32'h04010);
      chk("R7 rdata before", 32'(cfg_rdata), 32'h01);
      @(posedge clk);
      #1;
      cfg_we = 1'b0;
      chk("R7 after edge", 32'(phys_addr), 32'h18010);
      // R7: address alone changes output without a clock edge
      @(negedge clk);
      cpu_addr = 16'h8FFF;
      #1;
      chk("R7 comb", 32'(phys_addr), 32'h18FFF);

      // R9: data toggling without enable
      cfg_wdata = 8'hFF;
      @(negedge clk);
      cfg_wdata = 8'h00;
      @(negedge clk);
      #1;
      chk("R9 hold rdata", 32'(cfg_rdata), 32'h06);
      chk("R9 hold window", 32'(phys_addr), 32'h18FFF);

      // R6: high bits ignored on write
      write_page(8'hA9);
      #1;
      chk("R6 high bits", 32'(cfg_rdata), 32'h01);

      // R3 R4 R5 unaffected by page value 7
      write_page(8'h07);
      cpu_addr = 16'hD001; #1;
      chk("R3 page7", 32'(phys_addr), 32'h0D001);
      cpu_addr = 16'h5002; #1;
      chk("R4 page7", 32'(phys_addr), 32'h05002);
      cpu_addr = 16'h2003; #1;
      chk("R5 page7", 32'(phys_addr), 32'h02003);
      chk("R5 sel", 32'(sel_ram), 32'h1);

      // R1: reset mid-run restores page 2
      rst_n = 1'b0;
      #1;
      cpu_addr = 16'hB000; #1;
      chk("R1 re-reset", 32'(phys_addr), 32'h0B000);

      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule